// File: doc/BRIEF.md
# Double-Buffered Crosspoint Routing Core

This block is a crosspoint switch. Each output slice is a selector that passes exactly one of `NUM_IN` data inputs. There are `NUM_OUT` data slices plus one extra monitor slice, whose output feeds an external activity detector. The data path through every selector is purely combinational. Only the selection codes are held in registers.

Each slice keeps its selection code in two stages. A load command writes a staging (shadow) register. A separate apply strobe copies every staged value into the live (main) register that steers the selector. Many routes can therefore be queued and then switched at the same instant. Holding apply high makes each command take effect on its own. The load, apply, address-latch and initialize strobes are asynchronous to the system clock. Each one passes through a synchronizer and is then edge- or level-detected.

Commands arrive on a parallel port: an input code, an output address, and the strobes. A multiplexed variant latches the output address from the code lines when the address-latch-enable input falls. Any code at or above `NUM_IN`, such as all-ones (127 for 7-bit codes), idles that output and raises its off flag. An initialize pulse restores straight-through routing. The live codes of all slices are exposed on a flat readback bus.

Top module: `xpt_core`

## Requirements
- R1: After reset, data slice k selects input k (straight-through), the monitor slice selects input 0, and no off flag is raised.
- R2: A load command writes only the addressed slice's staging register; while apply stays low, no output and no readback field changes.
- R3: While the synchronized apply strobe is high, every staged code is copied to the live register on each clock, so several queued routes appear on the outputs together.
- R4: Once apply is low, live codes hold; later load commands do not alter outputs or readback until apply is raised again.
- R5: With apply held high, a load whose strobe rises just after a falling clock edge changes the output after the fourth following rising edge and not after the third.
- R6: With `mux_mode` high, the falling edge of `ale` latches the output address from `code_in[ADDR_W-1:0]`; subsequent loads use that latched address and ignore `out_addr`.
- R7: An initialize pulse restores straight-through codes in both staging and live registers of every slice.
- R8: A live code >= `NUM_IN` (e.g. 127) drives the slice output to 0 and raises its off flag; loading and applying a valid code re-enables it.
- R9: With `mon_sel` high and the address MSB (`ADDR_W-1`) set, a load targets the monitor slice only; with `mon_sel` high and the MSB clear, the normal data slice is addressed.
- R10: `rb_codes[k*CODE_W +: CODE_W]` holds the live code of data slice k, and field `NUM_OUT` holds the monitor slice's live code.
- R11: A load to an address >= `NUM_OUT` that does not select the monitor slice changes no slice.
- R12: Each enabled output equals its selected input in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_in | input | NUM_IN | Crosspoint data inputs |
| data_out | output | NUM_OUT | Crosspoint data outputs |
| mon_out | output | 1 | Monitor slice output |
| out_off | output | NUM_OUT | Per-output disabled flag |
| mon_off | output | 1 | Monitor slice disabled flag |
| code_in | input | CODE_W | Input code; carries the address in multiplexed mode |
| out_addr | input | ADDR_W | Output address (non-multiplexed mode) |
| load_stb | input | 1 | Load strobe, rising edge writes a staging register |
| apply_stb | input | 1 | Apply strobe, level copies staging to live |
| mux_mode | input | 1 | Selects the latched address from code_in |
| ale | input | 1 | Address latch enable, falling edge captures |
| mon_sel | input | 1 | Monitor-channel select |
| init_stb | input | 1 | Initialize strobe, rising edge restores straight-through |
| rb_codes | output | (NUM_OUT+1)*CODE_W | Live codes of all slices, slice 0 in the low field |

## Verification
The bench builds the core with 8 inputs, 8 data outputs, 7-bit codes and 4-bit addresses. The address space then has a spare half above the outputs, so ignored addresses and the monitor window can both be reached. The readback bus also fits in one 64-bit compare. At this size, every slice is swept through every valid code, one out-of-range code and the all-ones code, with outputs checked against computed patterns. Walking-one inputs, the exact apply-held latency, multiplexed addressing and initialization are covered as well.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
   localparam int SYNC_LEVEL = 0;
   localparam int SYNC_RISE  = 1;
   localparam int SYNC_FALL  = 2;

   // straight-through code of a data slice; slices beyond the inputs start idle
   function automatic int home_code(int slice, int n_in, int cw);
      if (slice < n_in) return slice;
      return (2 ** cw) - 1;
   endfunction
endpackage

// File: rtl/xpt_sync.sv
module xpt_sync
   import xpt_pkg::*;
#(
   parameter int STAGES = 2,
   parameter int MODE   = SYNC_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;
   logic              lvl;

   if (STAGES < 2) begin : g_bad_stages
      $error("xpt_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign lvl = chain[STAGES-1];

   if (MODE == SYNC_LEVEL) begin : g_level
      assign q = lvl;
   end else begin : g_edge
      logic prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev <= 1'b0;
         else        prev <= lvl;
      end
      if (MODE == SYNC_RISE) begin : g_rise
         assign q = lvl & ~prev;
      end else begin : g_fall
         assign q = ~lvl & prev;
      end
   end
endmodule

// File: rtl/xpt_decode.sv
module xpt_decode #(
   parameter int NUM_OUT = 36,
   parameter int CODE_W  = 7,
   parameter int ADDR_W  = 6,
   localparam int NSL    = NUM_OUT + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_evt,
   input  logic              ale_evt,
   input  logic              mux_mode,
   input  logic              mon_sel,
   input  logic [CODE_W-1:0] code_in,
   input  logic [ADDR_W-1:0] out_addr,
   output logic [NSL-1:0]    wr_vec,
   output logic [CODE_W-1:0] wr_code
);
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] eff_addr;
   logic              mon_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_q <= '0;
      else if (ale_evt) addr_q <= code_in[ADDR_W-1:0];
   end

   assign eff_addr = mux_mode ? addr_q : out_addr;
   assign mon_hit  = mon_sel & eff_addr[ADDR_W-1];
   assign wr_code  = code_in;

   for (genvar s = 0; s < NUM_OUT; s++) begin : g_dec
      assign wr_vec[s] = load_evt & ~mon_hit & (eff_addr == ADDR_W'(s));
   end
   assign wr_vec[NUM_OUT] = load_evt & mon_hit;
endmodule

// File: rtl/xpt_slice.sv
module xpt_slice #(
   parameter int NUM_IN = 36,
   parameter int CODE_W = 7,
   parameter int HOME   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              init_evt,
   input  logic              apply,
   input  logic [NUM_IN-1:0] data_in,
   output logic              sel_out,
   output logic              off,
   output logic [CODE_W-1:0] main_code,
   output logic [CODE_W-1:0] shadow_code
);
   localparam logic [CODE_W-1:0] HOME_C = CODE_W'(HOME);

   logic [CODE_W-1:0] shadow_q, main_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= HOME_C;
         main_q   <= HOME_C;
      end else if (init_evt) begin
         shadow_q <= HOME_C;
         main_q   <= HOME_C;
      end else begin
         if (wr_en) shadow_q <= wr_code;
         if (apply) main_q   <= shadow_q;
      end
   end

   // unregistered selector: out-of-range codes match nothing and give 0
   always_comb begin
      sel_out = 1'b0;
      for (int i = 0; i < NUM_IN; i++) begin
         if (main_q == CODE_W'(i)) sel_out = data_in[i];
      end
   end

   assign off         = (main_q >= CODE_W'(NUM_IN));
   assign main_code   = main_q;
   assign shadow_code = shadow_q;
endmodule

// File: rtl/xpt_core.sv
module xpt_core
   import xpt_pkg::*;
#(
   parameter int NUM_IN      = 36,
   parameter int NUM_OUT     = 36,
   parameter int CODE_W      = 7,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2,
   localparam int NSL        = NUM_OUT + 1,
   localparam int RB_W       = NSL * CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] data_in,
   output logic [NUM_OUT-1:0] data_out,
   output logic              mon_out,
   output logic [NUM_OUT-1:0] out_off,
   output logic              mon_off,
   input  logic [CODE_W-1:0] code_in,
   input  logic [ADDR_W-1:0] out_addr,
   input  logic              load_stb,
   input  logic              apply_stb,
   input  logic              mux_mode,
   input  logic              ale,
   input  logic              mon_sel,
   input  logic              init_stb,
   output logic [RB_W-1:0]   rb_codes
);
   if (NUM_IN > (2 ** CODE_W) - 1) begin : g_bad_code
      $error("xpt_core: CODE_W must leave at least one unused code");
   end
   if (NUM_OUT > (2 ** ADDR_W)) begin : g_bad_addr
      $error("xpt_core: ADDR_W too narrow for NUM_OUT");
   end
   if (CODE_W < ADDR_W) begin : g_bad_mux
      $error("xpt_core: code lines must be able to carry an address");
   end

   logic load_evt, apply_lvl, ale_evt, init_evt;

   xpt_sync #(.STAGES(SYNC_STAGES), .MODE(SYNC_RISE)) u_load_sync
      (.clk(clk), .rst_n(rst_n), .d(load_stb), .q(load_evt));
   xpt_sync #(.STAGES(SYNC_STAGES), .MODE(SYNC_LEVEL)) u_apply_sync
      (.clk(clk), .rst_n(rst_n), .d(apply_stb), .q(apply_lvl));
   xpt_sync #(.STAGES(SYNC_STAGES), .MODE(SYNC_FALL)) u_ale_sync
      (.clk(clk), .rst_n(rst_n), .d(ale), .q(ale_evt));
   xpt_sync #(.STAGES(SYNC_STAGES), .MODE(SYNC_RISE)) u_init_sync
      (.clk(clk), .rst_n(rst_n), .d(init_stb), .q(init_evt));

   logic [NSL-1:0]    wr_vec;
   logic [CODE_W-1:0] wr_code;

   xpt_decode #(.NUM_OUT(NUM_OUT), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_decode (
      .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .ale_evt(ale_evt),
      .mux_mode(mux_mode), .mon_sel(mon_sel), .code_in(code_in),
      .out_addr(out_addr), .wr_vec(wr_vec), .wr_code(wr_code)
   );

   logic [RB_W-1:0] sh_flat;
   logic [NSL-1:0]  sel_all, off_all;

   for (genvar s = 0; s < NSL; s++) begin : g_slice
      localparam int HOME_S = (s == NUM_OUT) ? 0 : home_code(s, NUM_IN, CODE_W);
      xpt_slice #(.NUM_IN(NUM_IN), .CODE_W(CODE_W), .HOME(HOME_S)) u_slice (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_vec[s]), .wr_code(wr_code),
         .init_evt(init_evt), .apply(apply_lvl), .data_in(data_in),
         .sel_out(sel_all[s]), .off(off_all[s]),
         .main_code(rb_codes[s*CODE_W +: CODE_W]),
         .shadow_code(sh_flat[s*CODE_W +: CODE_W])
      );
   end

   assign data_out = sel_all[NUM_OUT-1:0];
   assign out_off  = off_all[NUM_OUT-1:0];
   assign mon_out  = sel_all[NUM_OUT];
   assign mon_off  = off_all[NUM_OUT];
endmodule

// File: rtl/xpt_core_chk.sv
module xpt_core_chk #(
   parameter int NUM_IN  = 36,
   parameter int NUM_OUT = 36,
   parameter int CODE_W  = 7,
   localparam int NSL    = NUM_OUT + 1,
   localparam int RB_W   = NSL * CODE_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic [RB_W-1:0]    rb_codes,
   input logic [RB_W-1:0]    sh_flat,
   input logic               apply_lvl,
   input logic               init_evt,
   input logic [NSL-1:0]     wr_vec,
   input logic [NUM_OUT-1:0] data_out,
   input logic [NUM_OUT-1:0] out_off
);
   logic [RB_W-1:0] home_vec;

   always_comb begin
      home_vec = '0;
      for (int s = 0; s < NUM_OUT; s++) begin
         home_vec[s*CODE_W +: CODE_W] = (s < NUM_IN) ? CODE_W'(s) : '1;
      end
   end

   // R2: one command reaches at most one slice
   a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_vec));

   // R4: live codes hold without apply
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!apply_lvl && !init_evt) |=> $stable(rb_codes));

   // R3: apply copies all staged codes at once
   a_r3_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      (apply_lvl && !init_evt) |=> (rb_codes == $past(sh_flat)));

   // R7: initialize restores straight-through
   a_r7_init: assert property (@(posedge clk) disable iff (!rst_n)
      init_evt |=> (rb_codes == home_vec));

   for (genvar s = 0; s < NUM_OUT; s++) begin : g_out
      // R8: disabled output is idle and flag tracks the live code
      a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
         out_off[s] |-> !data_out[s]);
      a_r8_flag: assert property (@(posedge clk) disable iff (!rst_n)
         out_off[s] == (rb_codes[s*CODE_W +: CODE_W] >= CODE_W'(NUM_IN)));
   end
endmodule

bind xpt_core xpt_core_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rb_codes(rb_codes), .sh_flat(sh_flat),
   .apply_lvl(apply_lvl), .init_evt(init_evt), .wr_vec(wr_vec),
   .data_out(data_out), .out_off(out_off)
);

// File: tb/xpt_core_bench.sv
`timescale 1ns/1ps
module xpt_core_bench;
   localparam int NI = 8;
   localparam int NO = 8;
   localparam int CW = 7;
   localparam int AW = 4;
   localparam int NS = NO + 1;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [NI-1:0] data_in = '0;
   logic [NO-1:0] data_out, out_off;
   logic          mon_out, mon_off;
   logic [CW-1:0] code_in = '0;
   logic [AW-1:0] out_addr = '0;
   logic          load_stb = 1'b0, apply_stb = 1'b0, mux_mode = 1'b0;
   logic          ale = 1'b0, mon_sel = 1'b0, init_stb = 1'b0;
   logic [NS*CW-1:0] rb_codes;

   xpt_core #(.NUM_IN(NI), .NUM_OUT(NO), .CODE_W(CW), .ADDR_W(AW)) u_xpt_core (
      .clk(clk), .rst_n(rst_n), .data_in(data_in), .data_out(data_out),
      .mon_out(mon_out), .out_off(out_off), .mon_off(mon_off),
      .code_in(code_in), .out_addr(out_addr), .load_stb(load_stb),
      .apply_stb(apply_stb), .mux_mode(mux_mode), .ale(ale),
      .mon_sel(mon_sel), .init_stb(init_stb), .rb_codes(rb_codes)
   );

   int n_cmp = 0, n_bad = 0;
   int exp_sh[NS];
   int exp_main[NS];
   int latched = 0;
   bit finished = 0;

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic go_home();
      for (int s = 0; s < NS; s++) begin
         exp_sh[s]   = (s == NO) ? 0 : s;
         exp_main[s] = exp_sh[s];
      end
   endtask

   task automatic check_state(string req, logic [NI-1:0] pat);
      logic [NO-1:0] eo, ef;
      logic [63:0]   erb;
      logic          em, emf;
      data_in = pat;
      #1;
      erb = '0;
      for (int s = 0; s < NS; s++) erb[s*CW +: CW] = CW'(exp_main[s]);
      for (int s = 0; s < NO; s++) begin
         ef[s] = (exp_main[s] >= NI);
         eo[s] = ef[s] ? 1'b0 : pat[exp_main[s]];
      end
      emf = (exp_main[NO] >= NI);
      em  = emf ? 1'b0 : pat[exp_main[NO]];
      chk(req, "data_out", 64'(data_out), 64'(eo));
      chk(req, "out_off", 64'(out_off), 64'(ef));
      chk(req, "mon_out", 64'(mon_out), 64'(em));
      chk(req, "mon_off", 64'(mon_off), 64'(emf));
      chk("R10", "rb_codes", 64'(rb_codes), erb);
   endtask

   task automatic load(int addr, int code, bit mon);
      int eff, tgt;
      @(negedge clk);
      out_addr = AW'(addr); code_in = CW'(code); mon_sel = mon; load_stb = 1'b1;
      repeat (4) @(negedge clk);
      load_stb = 1'b0;
      repeat (3) @(negedge clk);
      mon_sel = 1'b0;
      eff = mux_mode ? latched : addr;
      if (mon && eff >= (1 << (AW-1))) tgt = NO;
      else if (eff < NO)               tgt = eff;
      else                             tgt = -1;
      if (tgt >= 0) exp_sh[tgt] = code;
   endtask

   task automatic apply_pulse();
      @(negedge clk);
      apply_stb = 1'b1;
      repeat (4) @(negedge clk);
      apply_stb = 1'b0;
      repeat (3) @(negedge clk);
      for (int s = 0; s < NS; s++) exp_main[s] = exp_sh[s];
   endtask

   task automatic init_pulse();
      @(negedge clk);
      init_stb = 1'b1;
      repeat (4) @(negedge clk);
      init_stb = 1'b0;
      repeat (3) @(negedge clk);
      go_home();
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog (all reqs): actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      go_home();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check_state("R1", 8'hA5);
      check_state("R1", 8'h3C);

      // R12: combinational selection with walking ones
      for (int i = 0; i < NI; i++) check_state("R12", NI'(1) << i);

      // R2: loads stay staged
      load(3, 5, 0);
      check_state("R2", 8'h96);
      load(0, 7, 0);
      load(7, 2, 0);
      check_state("R2", 8'h69);

      // R3: queued routes applied together
      apply_pulse();
      check_state("R3", 8'h96);
      check_state("R3", 8'h69);

      // R4: no effect after apply falls
      load(1, 4, 0);
      check_state("R4", 8'hF0);
      apply_pulse();
      check_state("R4", 8'h0F);

      // R3 / R8: sweep every slice over every code class
      for (int s = 0; s < NO; s++) begin
         for (int c = 0; c <= NI + 1; c++) begin
            int code;
            code = (c == NI + 1) ? 127 : c;
            load(s, code, 0);
            apply_pulse();
            check_state((code >= NI) ? "R8" : "R3", 8'hC3 ^ NI'(s * 17));
         end
      end

      // R8: disable then re-enable
      load(4, 127, 0);
      apply_pulse();
      check_state("R8", 8'hFF);
      load(4, 6, 0);
      apply_pulse();
      check_state("R8", 8'hFF);

      // R11: addresses beyond the outputs are ignored
      load(9, 3, 0);
      load(15, 1, 0);
      apply_pulse();
      check_state("R11", 8'h5A);

      // R9: monitor slice addressing
      load(8, 5, 1);
      apply_pulse();
      check_state("R9", 8'h20);
      check_state("R9", 8'hDF);
      load(3, 1, 1);
      apply_pulse();
      check_state("R9", 8'h02);

      // R6: multiplexed address latch
      mux_mode = 1'b1;
      @(negedge clk);
      code_in = CW'(6); ale = 1'b1;
      repeat (4) @(negedge clk);
      ale = 1'b0;
      repeat (4) @(negedge clk);
      latched = 6;
      load(1, 2, 0);
      apply_pulse();
      check_state("R6", 8'h04);
      check_state("R6", 8'hFB);
      mux_mode = 1'b0;

      // R7: initialize restores both stages
      load(5, 0, 0);
      init_pulse();
      check_state("R7", 8'hA5);
      apply_pulse();
      check_state("R7", 8'h5A);

      // R5: apply held high, exact latency
      @(negedge clk);
      apply_stb = 1'b1;
      repeat (4) @(negedge clk);
      out_addr = AW'(2); code_in = CW'(6); load_stb = 1'b1;
      repeat (3) @(negedge clk);
      check_state("R5", 8'h40);
      @(negedge clk);
      exp_sh[2] = 6; exp_main[2] = 6;
      check_state("R5", 8'h40);
      load_stb = 1'b0;
      repeat (3) @(negedge clk);
      apply_stb = 1'b0;
      repeat (4) @(negedge clk);
      check_state("R5", 8'hBF);

      finished = 1;
      summary();
      $finish;
   end
endmodule